// File: doc/BRIEF.md
# Cascadable Arithmetic/Logic Slice with 8-bit Chain

A combinational arithmetic and bitwise-logic unit built from identical 4-bit slices. Every slice takes two operand nibbles, a 4-bit function code, a mode bit and an active-low carry input. It returns a result nibble, an active-low carry output, and active-high group generate and propagate terms that an external lookahead unit could combine. The mode bit selects between sixteen arithmetic functions and sixteen bitwise functions. Inside a slice, each bit first forms two terms from the operand bits and the function code. In arithmetic mode, a two-level lookahead network turns those terms into the internal carries. In logic mode, the terms are combined directly and the carries play no part.

The top level places `NSLICE` slices side by side. The default is two slices, which gives an 8-bit datapath. Each slice's carry output drives the carry input of the next slice up. All slices share the function code and the mode bit. The slice group terms are merged into group terms for the whole word. An equality output is formed as the AND of all result bits.

Top module: `alu_cascade`

## Requirements
- R1: With mode=0, sel=4'b1001 and cin_n=1, f equals (a+b) mod 256, and cout_n is 0 exactly when a+b exceeds 255. This includes carries that cross from the low nibble into the high nibble.
- R2: With mode=0, sel=4'b0110 and cin_n=0, f equals (a-b) mod 256, and cout_n gives the sign: 0 when a>=b, 1 when a<b.
- R3: An active carry input (cin_n=0) adds one to the arithmetic result. For example, sel=4'b1001 then yields a+b+1.
- R4: With mode=0, sel=4'b0110 and cin_n=1, f equals a-b-1 and eq is 1 exactly when a equals b.
- R5: With mode=1, the result is a bitwise function of a and b that does not depend on cin_n. The codes are: 0000 gives not a; 0001 gives nor; 0100 gives nand; 0110 gives xor; 1001 gives xnor; 1011 gives and; 1110 gives or; 0011 gives zero; 1111 gives a.
- R6: The other arithmetic codes (mode=0), each plus one when cin_n=0, are: 0000 gives a; 1100 gives a+a; 1111 gives a-1; 0011 gives all ones.
- R7: In arithmetic mode, the inverted carry output equals grp_gen OR (grp_prop AND NOT cin_n).
- R8: For sel=4'b1001 in arithmetic mode, grp_prop is 1 exactly when every bit position has a or b set, and grp_gen is 1 exactly when a+b exceeds 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | Operand A (SLICE_W*NSLICE bits) |
| b | input | 8 | Operand B |
| sel | input | 4 | Function code shared by all slices |
| mode | input | 1 | 0 = arithmetic, 1 = bitwise logic |
| cin_n | input | 1 | Carry into the lowest slice, active low |
| f | output | 8 | Result word |
| cout_n | output | 1 | Carry out of the highest slice, active low |
| eq | output | 1 | AND of all result bits (equality in the R4 setup) |
| grp_gen | output | 1 | Group carry generate for the whole word |
| grp_prop | output | 1 | Group carry propagate for the whole word |

## Verification
The bound checker evaluates these on every input change: the add result and carry, the subtract sign, the equality flag, the logic-mode xor, and the consistency between the rippled carry and the merged group terms. The bench covers behaviour that no single snapshot can show. It sweeps every operand pair through add and subtract. It applies both carry-input values to a logic function and confirms they give the same result. It also exercises the remaining arithmetic codes, such as doubling, decrement and all-ones, as directed vectors.

// File: rtl/alu_cascade_pkg.sv
package alu_cascade_pkg;
   localparam logic [3:0] SEL_ADD = 4'b1001;
   localparam logic [3:0] SEL_SUB = 4'b0110;

   typedef enum logic {
      MODE_ARITH = 1'b0,
      MODE_LOGIC = 1'b1
   } alu_mode_e;
endpackage

// File: rtl/alu_term_former.sv
module alu_term_former #(
   parameter int W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [3:0]   sel,
   output logic [W-1:0] u,
   output logic [W-1:0] v
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_comb begin
         u[i] = a[i] | (b[i] & sel[0]) | (~b[i] & sel[1]);
         v[i] = (a[i] & ~b[i] & sel[2]) | (a[i] & b[i] & sel[3]);
      end
   end
endmodule

// File: rtl/alu_lookahead.sv
module alu_lookahead #(
   parameter int W = 4
) (
   input  logic [W-1:0] g,
   input  logic [W-1:0] p,
   input  logic         c0,
   output logic [W:0]   carry,
   output logic         grp_gen,
   output logic         grp_prop
);
   always_comb begin
      logic run;
      logic acc;
      for (int i = 0; i <= W; i++) begin
         acc = 1'b0;
         for (int j = 0; j < i; j++) begin
            run = g[j];
            for (int k = j + 1; k < i; k++) run = run & p[k];
            acc = acc | run;
         end
         run = c0;
         for (int k = 0; k < i; k++) run = run & p[k];
         carry[i] = acc | run;
      end
      acc = 1'b0;
      for (int j = 0; j < W; j++) begin
         run = g[j];
         for (int k = j + 1; k < W; k++) run = run & p[k];
         acc = acc | run;
      end
      grp_gen  = acc;
      grp_prop = &p;
   end
endmodule

// File: rtl/alu_slice.sv
module alu_slice #(
   parameter int W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [3:0]   sel,
   input  logic         mode,
   input  logic         cin_n,
   output logic [W-1:0] f,
   output logic         cout_n,
   output logic         gen,
   output logic         prop
);
   import alu_cascade_pkg::*;

   logic [W-1:0] u, v;
   logic [W:0]   carry;

   alu_term_former #(.W(W)) u_terms (
      .a(a), .b(b), .sel(sel), .u(u), .v(v)
   );

   alu_lookahead #(.W(W)) u_cla (
      .g(v), .p(u), .c0(~cin_n),
      .carry(carry), .grp_gen(gen), .grp_prop(prop)
   );

   always_comb begin
      if (alu_mode_e'(mode) == MODE_LOGIC) f = ~(u ^ v);
      else                                 f = u ^ v ^ carry[W-1:0];
      cout_n = ~carry[W];
   end
endmodule

// File: rtl/alu_cascade.sv
module alu_cascade #(
   parameter int SLICE_W = 4,
   parameter int NSLICE  = 2
) (
   input  logic [SLICE_W*NSLICE-1:0] a,
   input  logic [SLICE_W*NSLICE-1:0] b,
   input  logic [3:0]                sel,
   input  logic                      mode,
   input  logic                      cin_n,
   output logic [SLICE_W*NSLICE-1:0] f,
   output logic                      cout_n,
   output logic                      eq,
   output logic                      grp_gen,
   output logic                      grp_prop
);
   localparam int W = SLICE_W * NSLICE;

   if (SLICE_W < 1) begin : g_bad_w
      $error("SLICE_W must be at least 1");
   end
   if (NSLICE < 1) begin : g_bad_n
      $error("NSLICE must be at least 1");
   end

   logic [NSLICE:0]   cn;
   logic [NSLICE-1:0] s_gen, s_prop;

   assign cn[0] = cin_n;

   for (genvar k = 0; k < NSLICE; k++) begin : g_slice
      alu_slice #(.W(SLICE_W)) u_slice (
         .a     (a[k*SLICE_W +: SLICE_W]),
         .b     (b[k*SLICE_W +: SLICE_W]),
         .sel   (sel),
         .mode  (mode),
         .cin_n (cn[k]),
         .f     (f[k*SLICE_W +: SLICE_W]),
         .cout_n(cn[k+1]),
         .gen   (s_gen[k]),
         .prop  (s_prop[k])
      );
   end

   always_comb begin
      logic gacc;
      gacc = 1'b0;
      for (int k = 0; k < NSLICE; k++) gacc = s_gen[k] | (s_prop[k] & gacc);
      grp_gen  = gacc;
      grp_prop = &s_prop;
      cout_n   = cn[NSLICE];
      eq       = &f;
   end
endmodule

// File: rtl/alu_cascade_chk.sv
module alu_cascade_chk #(
   parameter int W = 8
) (
   input logic [W-1:0] a,
   input logic [W-1:0] b,
   input logic [3:0]   sel,
   input logic         mode,
   input logic         cin_n,
   input logic [W-1:0] f,
   input logic         cout_n,
   input logic         eq,
   input logic         grp_gen,
   input logic         grp_prop
);
   logic [W:0] add_ref;

   always_comb begin
      add_ref = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ~cin_n};
      if (!mode && sel == 4'b1001)
         AST_ADD_RESULT: assert ({~cout_n, f} == add_ref) else $error("add mismatch"); // R1
      if (!mode && sel == 4'b0110 && !cin_n)
         AST_SUB_SIGN: assert (cout_n == (a < b)) else $error("sign mismatch"); // R2
      if (!mode && sel == 4'b0110 && cin_n)
         AST_EQ_FLAG: assert (eq == (a == b)) else $error("eq mismatch"); // R4
      if (mode && sel == 4'b0110)
         AST_LOGIC_XOR: assert (f == (a ^ b)) else $error("xor mismatch"); // R5
      if (!mode)
         AST_GROUP_CARRY: assert (~cout_n == (grp_gen | (grp_prop & ~cin_n))) else $error("group mismatch"); // R7
      if (!mode && sel == 4'b1001)
         AST_ADD_PROP: assert (grp_prop == &(a | b)) else $error("prop mismatch"); // R8
   end
endmodule

bind alu_cascade alu_cascade_chk #(.W(W)) u_chk (
   .a(a), .b(b), .sel(sel), .mode(mode), .cin_n(cin_n),
   .f(f), .cout_n(cout_n), .eq(eq), .grp_gen(grp_gen), .grp_prop(grp_prop)
);

// File: tb/alu_cascade_bench.sv
module alu_cascade_bench;
   logic       clk = 1'b0;
   logic [7:0] a = 8'h00, b = 8'h00;
   logic [3:0] sel = 4'b0000;
   logic       mode = 1'b0, cin_n = 1'b1;
   logic [7:0] f;
   logic       cout_n, eq, grp_gen, grp_prop;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   alu_cascade u_alu_cascade (
      .a(a), .b(b), .sel(sel), .mode(mode), .cin_n(cin_n),
      .f(f), .cout_n(cout_n), .eq(eq), .grp_gen(grp_gen), .grp_prop(grp_prop)
   );

   // {mode, sel, cin_n, a, b, f_exp, check_cout, cout_n_exp}
   localparam logic [31:0] VEC [17] = '{
      {1'b0, 4'b1001, 1'b1, 8'h61, 8'h1D, 8'h7E, 1'b1, 1'b1},
      {1'b0, 4'b0110, 1'b0, 8'h61, 8'h1D, 8'h44, 1'b1, 1'b0},
      {1'b0, 4'b0110, 1'b0, 8'h1D, 8'h61, 8'hBC, 1'b1, 1'b1},
      {1'b0, 4'b1001, 1'b1, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0},
      {1'b0, 4'b1001, 1'b1, 8'h0F, 8'h01, 8'h10, 1'b1, 1'b1},
      {1'b0, 4'b1001, 1'b0, 8'h10, 8'h20, 8'h31, 1'b1, 1'b1},
      {1'b1, 4'b0000, 1'b0, 8'h5A, 8'h00, 8'hA5, 1'b0, 1'b0},
      {1'b1, 4'b0110, 1'b1, 8'hC3, 8'h5A, 8'h99, 1'b0, 1'b0},
      {1'b1, 4'b1011, 1'b1, 8'hC3, 8'h5A, 8'h42, 1'b0, 1'b0},
      {1'b1, 4'b1110, 1'b0, 8'hC3, 8'h5A, 8'hDB, 1'b0, 1'b0},
      {1'b1, 4'b0001, 1'b1, 8'hC3, 8'h5A, 8'h24, 1'b0, 1'b0},
      {1'b1, 4'b0100, 1'b0, 8'hC3, 8'h5A, 8'hBD, 1'b0, 1'b0},
      {1'b0, 4'b1100, 1'b1, 8'h81, 8'h00, 8'h02, 1'b1, 1'b0},
      {1'b0, 4'b1111, 1'b1, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b1},
      {1'b0, 4'b0011, 1'b1, 8'h5A, 8'h3C, 8'hFF, 1'b1, 1'b1},
      {1'b0, 4'b0011, 1'b0, 8'h5A, 8'h3C, 8'h00, 1'b1, 1'b0},
      {1'b0, 4'b0000, 1'b0, 8'h7F, 8'h11, 8'h80, 1'b1, 1'b1}
   };

   task automatic check(input string req, input string what,
                        input logic [8:0] act, input logic [8:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic m, input logic [3:0] s, input logic c,
                        input logic [7:0] x, input logic [7:0] y);
      @(posedge clk);
      mode = m; sel = s; cin_n = c; a = x; b = y;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      string tag;
      logic [8:0] ref_v;
      // idle state: zero operands, carry inactive -> zero result (R6)
      @(negedge clk);
      check("R6", "idle f", {1'b0, f}, 9'h000);
      check("R6", "idle cout_n", {8'h00, cout_n}, 9'h001);

      for (int i = 0; i < 17; i++) begin
         apply(VEC[i][31], VEC[i][30:27], VEC[i][26], VEC[i][25:18], VEC[i][17:10]);
         if (VEC[i][31])                tag = "R5";
         else if (VEC[i][30:27] == 4'b1001) tag = VEC[i][26] ? "R1" : "R3";
         else if (VEC[i][30:27] == 4'b0110) tag = "R2";
         else                           tag = "R6";
         check(tag, $sformatf("vec%0d f", i), {1'b0, f}, {1'b0, VEC[i][9:2]});
         if (VEC[i][1])
            check(tag, $sformatf("vec%0d cout_n", i), {8'h00, cout_n}, {8'h00, VEC[i][0]});
      end

      // logic result independent of the carry input (R5)
      apply(1'b1, 4'b0110, 1'b0, 8'hA5, 8'h0F);
      check("R5", "xor cin_n=0", {1'b0, f}, 9'h0AA);
      apply(1'b1, 4'b0110, 1'b1, 8'hA5, 8'h0F);
      check("R5", "xor cin_n=1", {1'b0, f}, 9'h0AA);

      // equality flag (R4)
      apply(1'b0, 4'b0110, 1'b1, 8'h3C, 8'h3C);
      check("R4", "eq equal", {8'h00, eq}, 9'h001);
      check("R4", "f equal", {1'b0, f}, 9'h0FF);
      apply(1'b0, 4'b0110, 1'b1, 8'h3C, 8'hBC);
      check("R4", "eq high differs", {8'h00, eq}, 9'h000);
      apply(1'b0, 4'b0110, 1'b1, 8'h3D, 8'h3C);
      check("R4", "eq low differs", {8'h00, eq}, 9'h000);

      // group terms (R8) and their relation to the carry (R7)
      apply(1'b0, 4'b1001, 1'b1, 8'hF0, 8'h0F);
      check("R8", "prop all", {8'h00, grp_prop}, 9'h001);
      check("R8", "gen none", {8'h00, grp_gen}, 9'h000);
      apply(1'b0, 4'b1001, 1'b0, 8'hF0, 8'h0F);
      check("R7", "cout via prop", {8'h00, cout_n}, 9'h000);
      check("R7", "f wrap", {1'b0, f}, 9'h000);
      apply(1'b0, 4'b1001, 1'b1, 8'h80, 8'h80);
      check("R8", "gen top", {8'h00, grp_gen}, 9'h001);
      apply(1'b0, 4'b1001, 1'b1, 8'h00, 8'h01);
      check("R8", "prop gap", {8'h00, grp_prop}, 9'h000);

      // exhaustive add sweep (R1, R8)
      for (int x = 0; x < 256; x++) begin
         for (int y = 0; y < 256; y++) begin
            apply(1'b0, 4'b1001, 1'b1, 8'(x), 8'(y));
            ref_v = 9'(x + y);
            check("R1", "sweep add f", {1'b0, f}, {1'b0, ref_v[7:0]});
            check("R1", "sweep add cout_n", {8'h00, cout_n}, {8'h00, ~ref_v[8]});
            check("R8", "sweep gen", {8'h00, grp_gen}, {8'h00, ref_v[8]});
         end
      end

      // exhaustive subtract sweep (R2)
      for (int x = 0; x < 256; x++) begin
         for (int y = 0; y < 256; y++) begin
            apply(1'b0, 4'b0110, 1'b0, 8'(x), 8'(y));
            ref_v = 9'(x - y);
            check("R2", "sweep sub f", {1'b0, f}, {1'b0, ref_v[7:0]});
            check("R2", "sweep sub sign", {8'h00, cout_n}, {8'h00, (x < y)});
         end
      end

      done = 1'b1;
      finish_run();
   end
endmodule